// File: doc/BRIEF.md
# Sticky Status Flag Register

This block keeps one status byte. Its low six bits are sticky flags that hardware event pulses set. The host clears them under separate rules for each flag. The two top bits are live levels: a temperature-conversion busy indication and an oscillator-stopped indication. A host port supplies address, write enable, write data and read enable. A separate strobe marks the point where a read transaction has ended with a proper stop. An enable input turns on automatic clearing after a read.

Each flag has its own clear rules:

- The power-loss flag ignores host writes to the status byte. The first write to any timekeeping address clears it.
- The alarm flag accepts only zero writes, which clear it.
- The voltage-low and two battery-low flags, and the alarm flag, clear after a completed status read when auto-clear is on.
- The daylight-saving flag clears after any completed status read, and also on a month-change tick.

Read data shows the flags live. Auto-clear acts only on flags that were already set when the status byte was captured. A flag raised later in the same transaction survives. When a set and a clear fall in the same cycle, the set wins. While busy is high, the block also reports that accesses to the trimming address window are blocked.

Top module: `sts_status_reg`

## Requirements
- R1: After reset, bits 5:0 of the status byte at address STAT_ADDR read 0. The bit order from bit 7 down to bit 0 is: busy, oscillator stop, daylight-saving, alarm, voltage-low, battery-85, battery-75, power-loss.
- R2: An event pulse sets its flag at the next clock edge. The flag then holds without further pulses.
- R3: A write to the status address leaves the power-loss flag unchanged. Any write to an address in 0..TIME_LAST clears it.
- R4: A status write with data bit 4 at 0 clears the alarm flag. With data bit 4 at 1, the alarm flag is unchanged.
- R5: With auto-clear enabled, a completed read clears those of alarm, voltage-low, battery-85 and battery-75 that were set when rd_en_i captured the status byte.
- R6: A flag whose event arrives after the capture and before rd_done_i stays set after the completed read.
- R7: With auto-clear disabled, a completed read leaves alarm, voltage-low and both battery flags unchanged.
- R8: A completed status read clears a captured daylight-saving flag, whatever the auto-clear setting.
- R9: A month-change tick clears the daylight-saving flag.
- R10: When a set event and a clear condition for the same flag fall in one cycle, the flag ends up set.
- R11: Bits 7 and 6 follow busy_i and osc_stop_i combinationally. trim_blocked_o is high exactly when busy_i is high and a read or write addresses TRIM_LO..TRIM_HI.
- R12: rd_done_i with no status capture since the previous completed read clears nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| pwr_lost_i | input | 1 | Pulse: power-up after total supply loss |
| dst_evt_i | input | 1 | Pulse: daylight-saving adjustment happened |
| alm_evt_i | input | 1 | Pulse: alarm match |
| vlow_evt_i | input | 1 | Pulse: supply below trip level |
| bat85_evt_i | input | 1 | Pulse: battery below 85% trip |
| bat75_evt_i | input | 1 | Pulse: battery below 75% trip |
| month_tick_i | input | 1 | Pulse: month rolled over |
| busy_i | input | 1 | Level: temperature conversion active |
| osc_stop_i | input | 1 | Level: oscillator stopped |
| auto_clr_en_i | input | 1 | Auto-clear after completed read |
| addr_i | input | ADDR_W | Host register address |
| wr_en_i | input | 1 | Host write strobe |
| wdata_i | input | 8 | Host write data |
| rd_en_i | input | 1 | Host read capture strobe |
| rd_done_i | input | 1 | Read transaction completed with stop |
| rdata_o | output | 8 | Status byte when addr_i is STAT_ADDR, else 0 |
| trim_blocked_o | output | 1 | Trim-window access refused during busy |

## Verification
The bench uses the default build: a 4-bit address, the status byte at 7, timekeeping at 0..6 and the trim window at 10..11. With these settings, one sweep over all 16 addresses covers every address class, for both the power-loss clear and the trim blocking. The four auto-cleared flags give only 16 set patterns, so every pattern is read back with auto-clear on and with it off. Each of those flags is also raised between capture and completion, to confirm it survives.

// File: rtl/sts_pkg.sv
package sts_pkg;
    localparam int NFLAG = 6;
    // sticky flag positions inside the status byte
    localparam int F_PWR  = 0;
    localparam int F_B75  = 1;
    localparam int F_B85  = 2;
    localparam int F_VLOW = 3;
    localparam int F_ALM  = 4;
    localparam int F_DST  = 5;

    typedef struct packed {
        logic             pend;
        logic [NFLAG-1:0] snap;
    } rd_trk_t;
endpackage

// File: rtl/sts_sticky_bit.sv
module sts_sticky_bit (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic set_i,
    input  logic clr_i,
    output logic q_o
);
    logic flag_d, flag_q;

    always_comb begin
        flag_d = flag_q;
        if (clr_i) flag_d = 1'b0;
        if (set_i) flag_d = 1'b1;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) flag_q <= 1'b0;
        else         flag_q <= flag_d;
    end

    assign q_o = flag_q;

    // R10
    set_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        set_i |=> q_o);

    // R2
    hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (q_o && !clr_i) |=> q_o);
endmodule

// File: rtl/sts_read_track.sv
module sts_read_track
    import sts_pkg::*;
(
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             cap_i,
    input  logic             done_i,
    input  logic [NFLAG-1:0] flags_i,
    output logic [NFLAG-1:0] clr_mask_o
);
    rd_trk_t trk_d, trk_q;

    always_comb begin
        trk_d      = trk_q;
        clr_mask_o = '0;
        if (done_i && trk_q.pend) begin
            clr_mask_o = trk_q.snap;
            trk_d.pend = 1'b0;
            trk_d.snap = '0;
        end
        if (cap_i) begin
            trk_d.pend = 1'b1;
            trk_d.snap = trk_d.snap | flags_i;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) trk_q <= '0;
        else         trk_q <= trk_d;
    end

    // R12
    no_pend_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (done_i && !trk_q.pend) |-> (clr_mask_o == '0));
endmodule

// File: rtl/sts_status_reg.sv
module sts_status_reg
    import sts_pkg::*;
#(
    parameter int ADDR_W    = 4,
    parameter int STAT_ADDR = 7,
    parameter int TIME_LAST = 6,
    parameter int TRIM_LO   = 10,
    parameter int TRIM_HI   = 11
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              pwr_lost_i,
    input  logic              dst_evt_i,
    input  logic              alm_evt_i,
    input  logic              vlow_evt_i,
    input  logic              bat85_evt_i,
    input  logic              bat75_evt_i,
    input  logic              month_tick_i,
    input  logic              busy_i,
    input  logic              osc_stop_i,
    input  logic              auto_clr_en_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              wr_en_i,
    input  logic [7:0]        wdata_i,
    input  logic              rd_en_i,
    input  logic              rd_done_i,
    output logic [7:0]        rdata_o,
    output logic              trim_blocked_o
);
    localparam logic [ADDR_W-1:0] STAT_A  = ADDR_W'(STAT_ADDR);
    localparam logic [ADDR_W-1:0] TIME_A  = ADDR_W'(TIME_LAST);
    localparam logic [ADDR_W-1:0] TRLO_A  = ADDR_W'(TRIM_LO);
    localparam logic [ADDR_W-1:0] TRHI_A  = ADDR_W'(TRIM_HI);
    localparam logic [NFLAG-1:0]  AUTO_M  = NFLAG'((1 << F_ALM) | (1 << F_VLOW) |
                                                   (1 << F_B85) | (1 << F_B75));

    logic             stat_sel, wr_stat, rd_stat, time_wr;
    logic [NFLAG-1:0] set_v, clr_v, flags_q, done_mask;

    assign stat_sel = (addr_i == STAT_A);
    assign wr_stat  = wr_en_i && stat_sel;
    assign rd_stat  = rd_en_i && stat_sel;
    assign time_wr  = wr_en_i && (addr_i <= TIME_A);

    sts_read_track u_trk (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .cap_i      (rd_stat),
        .done_i     (rd_done_i),
        .flags_i    (flags_q),
        .clr_mask_o (done_mask)
    );

    always_comb begin
        set_v        = '0;
        set_v[F_PWR] = pwr_lost_i;
        set_v[F_B75] = bat75_evt_i;
        set_v[F_B85] = bat85_evt_i;
        set_v[F_VLOW]= vlow_evt_i;
        set_v[F_ALM] = alm_evt_i;
        set_v[F_DST] = dst_evt_i;

        clr_v        = auto_clr_en_i ? (done_mask & AUTO_M) : '0;
        clr_v[F_PWR] = time_wr;
        if (wr_stat && !wdata_i[F_ALM]) clr_v[F_ALM] = 1'b1;
        clr_v[F_DST] = done_mask[F_DST] || month_tick_i;
    end

    for (genvar i = 0; i < NFLAG; i++) begin : g_flag
        sts_sticky_bit u_bit (
            .clk_i  (clk_i),
            .rst_ni (rst_ni),
            .set_i  (set_v[i]),
            .clr_i  (clr_v[i]),
            .q_o    (flags_q[i])
        );
    end

    assign rdata_o        = stat_sel ? {busy_i, osc_stop_i, flags_q} : 8'h00;
    assign trim_blocked_o = busy_i && (rd_en_i || wr_en_i) &&
                            (addr_i >= TRLO_A) && (addr_i <= TRHI_A);

    // R2
    alm_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        alm_evt_i |=> flags_q[F_ALM]);

    // R4
    alm_wr_one_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_stat && wdata_i[F_ALM] && !flags_q[F_ALM] && !alm_evt_i) |=> !flags_q[F_ALM]);

    // R3
    pwr_stat_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_stat && !pwr_lost_i && !time_wr) |=> $stable(flags_q[F_PWR]));

    // R9
    dst_month_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (month_tick_i && !dst_evt_i) |=> !flags_q[F_DST]);

    // R7
    no_auto_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rd_done_i && !auto_clr_en_i && !wr_en_i) |=>
            ((flags_q & AUTO_M) == ($past(flags_q) & AUTO_M)) ||
            ($past(alm_evt_i || vlow_evt_i || bat85_evt_i || bat75_evt_i)));
endmodule

// File: tb/tb_sts_status_reg.sv
module tb_sts_status_reg;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [5:0] evt = '0;
    logic       month = 1'b0, busy = 1'b0, osc = 1'b0, auto_en = 1'b0;
    logic [3:0] addr = 4'd7;
    logic       wr_en = 1'b0, rd_en = 1'b0, rd_done = 1'b0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic       trim_blk;

    int n_chk = 0, n_bad = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sts_status_reg dut (
        .clk_i(clk), .rst_ni(rst_n),
        .pwr_lost_i(evt[0]), .bat75_evt_i(evt[1]), .bat85_evt_i(evt[2]),
        .vlow_evt_i(evt[3]), .alm_evt_i(evt[4]), .dst_evt_i(evt[5]),
        .month_tick_i(month), .busy_i(busy), .osc_stop_i(osc),
        .auto_clr_en_i(auto_en), .addr_i(addr), .wr_en_i(wr_en),
        .wdata_i(wdata), .rd_en_i(rd_en), .rd_done_i(rd_done),
        .rdata_o(rdata), .trim_blocked_o(trim_blk)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic peek(input string tag, input logic [5:0] exp_flags);
        addr = 4'd7;
        #1;
        chk(tag, rdata, {busy, osc, exp_flags});
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic fire(input logic [5:0] m);
        evt = m;
        @(negedge clk);
        evt = '0;
    endtask

    task automatic rd_cap();
        addr = 4'd7; rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic rd_end();
        rd_done = 1'b1;
        @(negedge clk);
        rd_done = 1'b0;
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    initial begin
        @(negedge clk);
        do_reset();
        // R1 reset state
        peek("R1 reset", 6'h00);

        // R11 level pass-through
        for (int b = 0; b < 4; b++) begin
            busy = b[1]; osc = b[0];
            peek("R11 levels", 6'h00);
        end
        busy = 0; osc = 0;

        // R2 each flag set and held
        for (int k = 0; k < 6; k++) begin
            do_reset();
            fire(6'(1 << k));
            peek("R2 set", 6'(1 << k));
            @(negedge clk); @(negedge clk);
            peek("R2 hold", 6'(1 << k));
        end

        // R4 write-one keeps, write-zero clears
        do_reset();
        fire(6'h10);
        wr(4'd7, 8'hFF);
        peek("R4 wr1 keep", 6'h10);
        wr(4'd7, 8'h00);
        peek("R4 wr0 clear", 6'h00);
        wr(4'd7, 8'hFF);
        peek("R4 wr1 no set", 6'h00);

        // R10 set beats write-zero clear
        do_reset();
        addr = 4'd7; wdata = 8'h00; wr_en = 1'b1; evt = 6'h10;
        @(negedge clk);
        wr_en = 1'b0; evt = '0;
        peek("R10 set wins", 6'h10);

        // R3 power-loss flag across all addresses; R11 trim block during busy
        for (int a = 0; a < 16; a++) begin
            do_reset();
            fire(6'h01);
            busy = 1'b1;
            addr = 4'(a); wdata = 8'h00; wr_en = 1'b1;
            #1;
            chk("R11 trim block", {7'd0, trim_blk}, {7'd0, (a >= 10 && a <= 11)});
            @(negedge clk);
            wr_en = 1'b0;
            peek("R3 pwr clear", {5'd0, (a > 6)});
            busy = 1'b0;
        end

        // R5 / R7 all 16 patterns, auto on and off
        for (int au = 0; au < 2; au++) begin
            for (int p = 0; p < 16; p++) begin
                do_reset();
                auto_en = au[0];
                fire({1'b0, 4'(p), 1'b0});
                rd_cap();
                rd_end();
                peek(au ? "R5 auto clear" : "R7 auto off",
                     au ? 6'h00 : {1'b0, 4'(p), 1'b0});
            end
        end

        // R6 late event survives
        for (int k = 1; k < 5; k++) begin
            do_reset();
            auto_en = 1'b1;
            rd_cap();
            fire(6'(1 << k));
            rd_end();
            peek("R6 late event", 6'(1 << k));
        end

        // R8 dst cleared by completed read with auto off
        do_reset();
        auto_en = 1'b0;
        fire(6'h20);
        rd_cap();
        peek("R8 before done", 6'h20);
        rd_end();
        peek("R8 read clear", 6'h00);

        // R9 month tick clears dst
        do_reset();
        fire(6'h20);
        month = 1'b1;
        @(negedge clk);
        month = 1'b0;
        peek("R9 month clear", 6'h00);

        // R12 done without capture
        do_reset();
        auto_en = 1'b1;
        fire(6'h3E);
        rd_end();
        peek("R12 no capture", 6'h3E);

        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end
endmodule